// File: doc/BRIEF.md
# Clock-Synchronous Full-Duplex Serial Transceiver

This block moves bytes over a three-wire clocked serial link as the clock master, sending and receiving at the same time. Software loads a byte into the transmit buffer over a small word-addressed register bus. The byte passes to a transmit shifter while the receive shifter collects the byte coming back on the input pin. When a frame ends, the received byte lands in a receive buffer. Both directions are double-buffered, so software can queue the next byte while the current one is still on the wire. Frames then follow each other with no idle gap.

Four status flags report the state of the link: transmit buffer empty, receive buffer full, link gone quiet, and receive overrun. Reading the receive buffer and writing the transmit buffer clear their own flags. Software clears the other two flags by writing a 0 to them. An overrun halts the link until software clears it. The serial clock comes from the system clock through a divider with four ratios. A level interrupt reports a waiting received byte.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, status (address 1) reads 0x01 (bit0 transmit-empty = 1, all others 0), control (address 0) reads 0x00, `ser_clk` and `ser_dout` are high, and `rx_irq` is low.
- R2: A write to address 2 fills the transmit buffer and clears status bit0. When the buffer moves into the shifter, bit0 returns to 1 while the frame is still running, and a byte written then starts the next frame directly after the current one.
- R3: A frame is 8 bits, MSB first. `ser_dout` changes only with a falling `ser_clk`, and `ser_din` is captured at each rising `ser_clk`. `ser_clk` idles high. Each low and each high half lasts H = 2 << S system clocks, where S is control bits [5:4].
- R4: One half period after the 8th rising edge, the frame ends. If receive is enabled and status bit1 is 0, the byte goes to address 3 and bit1 is set. A read of address 3 returns the byte and clears bit1.
- R5: `rx_irq` is high exactly while status bit1 is 1 and control bit2 is 1.
- R6: If a frame ends with receive enabled while bit1 is already 1, status bit3 (overrun) is set and address 3 keeps its old byte.
- R7: While bit3 is 1, no frame starts. Writing 0 to status bit3 clears it, and writing 1 to it has no effect.
- R8: Status bit2 (link quiet) is set 3H clocks after the 8th rising edge of a frame when no byte is waiting. It is cleared when a frame starts or when 0 is written to it. Writing 1 to it has no effect.
- R9: A frame starts only while control bit0 (transmit enable) or bit1 (receive enable) is 1. Clearing both ends any frame, and `ser_clk` and `ser_dout` return high on the next clock.
- R10: With bit0 = 0 and bit1 = 1, a written byte still runs a frame that receives normally, but `ser_dout` stays high.
- R11: With bit1 = 0, a completed frame leaves status bit1, status bit3 and address 3 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 control, 1 status, 2 transmit, 3 receive |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not selected |
| rx_irq | output | 1 | Receive interrupt level |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_dout | output | 1 | Serial data out |
| ser_din | input | 1 | Serial data in |

## Verification
The bench drives a loopback slave that updates `ser_din` on each falling serial clock. It goes after back-to-back frames across all four divide ratios. A design that set transmit-empty too late would insert gaps or drop the queued byte, and a wrong divider would show up in the measured half periods. The bench forces an overrun by leaving the receive buffer unread. A faulty block would then overwrite the held byte or keep shifting the next byte before software clears the flag. The bench samples the quiet flag one clock before and at the 3H point, which catches an off-by-one tail. It also runs a receive-only frame, a transmit-only frame and a mid-frame shutdown. Each of these exposes a data pin that toggles, a receive flag that moves, or a clock that keeps running.

// File: rtl/ssx_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the clock-synchronous serial transceiver:
// register addresses, field positions and the engine state type.
package ssx_pkg;

    // Word addresses on the register bus.
    localparam logic [1:0] ADR_CTRL = 2'd0;
    localparam logic [1:0] ADR_STAT = 2'd1;
    localparam logic [1:0] ADR_TXD  = 2'd2;
    localparam logic [1:0] ADR_RXD  = 2'd3;

    // Control register fields.
    localparam int CTL_TXEN   = 0;
    localparam int CTL_RXEN   = 1;
    localparam int CTL_IRQEN  = 2;
    localparam int CTL_DIV_LO = 4;

    // Status register fields.
    localparam int ST_TXE  = 0;
    localparam int ST_RXF  = 1;
    localparam int ST_TEND = 2;
    localparam int ST_OVR  = 3;

    // Serial engine phases.
    typedef enum logic [2:0] {
        ENG_IDLE,
        ENG_LOW,
        ENG_HIGH,
        ENG_TAIL1,
        ENG_TAIL2
    } eng_state_t;

endpackage

// File: rtl/ssx_divider.sv
`timescale 1ns/1ps
// Half-period timer for the serial clock.
// Produces a one-cycle tick every H = BASE_HALF << div_sel system clocks
// while the engine runs. Assumes restart is pulsed when a frame is launched
// and that H never exceeds 2**CNT_W.
module ssx_divider #(
    parameter int SEL_W     = 2,
    parameter int BASE_HALF = 2,
    parameter int CNT_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] div_sel,
    output logic             tick
);

    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] cnt_q;

    // Reload value for the selected ratio.
    always_comb half_m1 = CNT_W'((BASE_HALF << div_sel) - 1);

    assign tick = run && (cnt_q == '0);

    // Count down one half period, reloading on expiry, restart or idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart || tick) begin
            cnt_q <= half_m1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/ssx_engine.sv
`timescale 1ns/1ps
// Serial shift engine (clock master).
// Drives ser_clk low and shows the next data bit on each falling phase,
// captures ser_din at the end of each low phase (the rising edge), and after
// the last bit waits a full bit period before reporting the link quiet.
// Assumes start_ok already reflects buffer state and overrun blocking.
module ssx_engine
    import ssx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              start_ok,
    input  logic              tick,
    input  logic              ser_din,
    input  logic [DATA_W-1:0] tx_byte,
    output logic              load,
    output logic              frame_done,
    output logic              tail_done,
    output logic              running,
    output logic              ser_clk,
    output logic              ser_dout,
    output logic [DATA_W-1:0] rx_byte
);

    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    eng_state_t        state_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic              sck_q;
    logic              sdo_q;
    logic              any_en;
    logic              can_take;

    assign any_en     = tx_en || rx_en;
    assign frame_done = any_en && (state_q == ENG_HIGH) && tick && (bit_q == LAST_BIT);
    assign can_take   = (state_q == ENG_IDLE) || (state_q == ENG_TAIL1) ||
                        (state_q == ENG_TAIL2) || frame_done;
    assign load       = any_en && start_ok && can_take;
    assign tail_done  = any_en && (state_q == ENG_TAIL2) && tick && !load;
    assign running    = (state_q != ENG_IDLE);
    assign ser_clk    = sck_q;
    assign ser_dout   = sdo_q;
    assign rx_byte    = rx_sh_q;

    // Phase sequencing, shifting and pin drive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ENG_IDLE;
            bit_q   <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
            sck_q   <= 1'b1;
            sdo_q   <= 1'b1;
        end else if (!any_en) begin
            state_q <= ENG_IDLE;
            sck_q   <= 1'b1;
            sdo_q   <= 1'b1;
        end else if (load) begin
            tx_sh_q <= tx_byte;
            sdo_q   <= tx_en ? tx_byte[DATA_W-1] : 1'b1;
            sck_q   <= 1'b0;
            bit_q   <= '0;
            state_q <= ENG_LOW;
        end else begin
            case (state_q)
                ENG_LOW: begin
                    if (tick) begin
                        sck_q   <= 1'b1;
                        rx_sh_q <= {rx_sh_q[DATA_W-2:0], ser_din};
                        state_q <= ENG_HIGH;
                    end
                end
                ENG_HIGH: begin
                    if (tick) begin
                        if (bit_q == LAST_BIT) begin
                            sdo_q   <= 1'b1;
                            state_q <= ENG_TAIL1;
                        end else begin
                            bit_q   <= bit_q + 1'b1;
                            tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                            sdo_q   <= tx_en ? tx_sh_q[DATA_W-2] : 1'b1;
                            sck_q   <= 1'b0;
                            state_q <= ENG_LOW;
                        end
                    end
                end
                ENG_TAIL1: if (tick) state_q <= ENG_TAIL2;
                ENG_TAIL2: if (tick) state_q <= ENG_IDLE;
                default:   state_q <= ENG_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ssx_regs.sv
`timescale 1ns/1ps
// Register file and flag logic.
// Holds control, the transmit and receive buffers and the four status flags.
// Flags are updated by bus accesses and engine events. Assumes one bus
// access per cycle; read data is combinational.
module ssx_regs
    import ssx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              load,
    input  logic              frame_done,
    input  logic              tail_done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              tx_en,
    output logic              rx_en,
    output logic [SEL_W-1:0]  div_sel,
    output logic [DATA_W-1:0] tx_byte,
    output logic              start_ok,
    output logic              rx_irq,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              ovr,
    output logic [DATA_W-1:0] rx_data
);

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] txb_q;
    logic [DATA_W-1:0] rxb_q;
    logic              txe_q, rxf_q, tend_q, ovr_q;
    logic              wr_ctrl, wr_stat, wr_tx, rd_rx;
    logic              rxf_eff, ovr_hit, rx_take;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADR_CTRL);
    assign wr_stat = bus_sel && bus_wr && (bus_addr == ADR_STAT);
    assign wr_tx   = bus_sel && bus_wr && (bus_addr == ADR_TXD);
    assign rd_rx   = bus_sel && !bus_wr && (bus_addr == ADR_RXD);

    assign rxf_eff  = rxf_q && !rd_rx;
    assign ovr_hit  = frame_done && rx_en && rxf_eff;
    assign rx_take  = frame_done && rx_en && !rxf_eff;
    assign start_ok = !txe_q && !ovr_q && !ovr_hit;

    assign tx_en    = ctrl_q[CTL_TXEN];
    assign rx_en    = ctrl_q[CTL_RXEN];
    assign div_sel  = ctrl_q[CTL_DIV_LO +: SEL_W];
    assign tx_byte  = txb_q;
    assign rx_irq   = rxf_q && ctrl_q[CTL_IRQEN];
    assign tx_empty = txe_q;
    assign rx_full  = rxf_q;
    assign ovr      = ovr_q;
    assign rx_data  = rxb_q;

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (bus_addr)
                ADR_CTRL: bus_rdata = ctrl_q;
                ADR_STAT: begin
                    bus_rdata[ST_TXE]  = txe_q;
                    bus_rdata[ST_RXF]  = rxf_q;
                    bus_rdata[ST_TEND] = tend_q;
                    bus_rdata[ST_OVR]  = ovr_q;
                end
                ADR_RXD:  bus_rdata = rxb_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    // Control and transmit buffer writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            txb_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= bus_wdata;
            if (wr_tx)   txb_q  <= bus_wdata;
        end
    end

    // Transmit-empty: cleared by a buffer write, set when the shifter takes it.
    always_ff @(posedge clk) begin
        if (!rst_n)      txe_q <= 1'b1;
        else if (wr_tx)  txe_q <= 1'b0;
        else if (load)   txe_q <= 1'b1;
    end

    // Receive buffer and receive-full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rxb_q <= '0;
            rxf_q <= 1'b0;
        end else if (rx_take) begin
            rxb_q <= rx_byte;
            rxf_q <= 1'b1;
        end else if (rd_rx) begin
            rxf_q <= 1'b0;
        end
    end

    // Overrun flag: set on a completion into a full buffer, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovr_q <= 1'b0;
        else if (ovr_hit)                        ovr_q <= 1'b1;
        else if (wr_stat && !bus_wdata[ST_OVR])  ovr_q <= 1'b0;
    end

    // Link-quiet flag: set after the tail period, cleared by a frame start or a 0 write.
    always_ff @(posedge clk) begin
        if (!rst_n)                              tend_q <= 1'b0;
        else if (tail_done)                      tend_q <= 1'b1;
        else if (load)                           tend_q <= 1'b0;
        else if (wr_stat && !bus_wdata[ST_TEND]) tend_q <= 1'b0;
    end

endmodule

// File: rtl/sync_serial_xcvr.sv
`timescale 1ns/1ps
// Top of the clock-synchronous full-duplex serial transceiver (master only).
// Connects the register file, the half-period divider and the shift engine.
// Assumes a single clock domain; ser_din must be synchronous to clk.
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int SEL_W     = 2,
    parameter int BASE_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rx_irq,
    output logic              ser_clk,
    output logic              ser_dout,
    input  logic              ser_din
);

    localparam int MAX_HALF = BASE_HALF << ((1 << SEL_W) - 1);
    localparam int CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

    logic              ctl_tx_en, ctl_rx_en;
    logic [SEL_W-1:0]  ctl_div;
    logic [DATA_W-1:0] tx_byte, rx_byte, rx_buf;
    logic              start_ok, eng_load, eng_done, eng_tail, eng_run, half_tick;
    logic              st_tx_empty, st_rx_full, st_ovr;

    ssx_regs #(
        .DATA_W (DATA_W),
        .SEL_W  (SEL_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .load       (eng_load),
        .frame_done (eng_done),
        .tail_done  (eng_tail),
        .rx_byte    (rx_byte),
        .tx_en      (ctl_tx_en),
        .rx_en      (ctl_rx_en),
        .div_sel    (ctl_div),
        .tx_byte    (tx_byte),
        .start_ok   (start_ok),
        .rx_irq     (rx_irq),
        .tx_empty   (st_tx_empty),
        .rx_full    (st_rx_full),
        .ovr        (st_ovr),
        .rx_data    (rx_buf)
    );

    ssx_divider #(
        .SEL_W     (SEL_W),
        .BASE_HALF (BASE_HALF),
        .CNT_W     (CNT_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (eng_run),
        .restart (eng_load),
        .div_sel (ctl_div),
        .tick    (half_tick)
    );

    ssx_engine #(
        .DATA_W (DATA_W)
    ) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (ctl_tx_en),
        .rx_en      (ctl_rx_en),
        .start_ok   (start_ok),
        .tick       (half_tick),
        .ser_din    (ser_din),
        .tx_byte    (tx_byte),
        .load       (eng_load),
        .frame_done (eng_done),
        .tail_done  (eng_tail),
        .running    (eng_run),
        .ser_clk    (ser_clk),
        .ser_dout   (ser_dout),
        .rx_byte    (rx_byte)
    );

endmodule

// File: rtl/ssx_chk.sv
`timescale 1ns/1ps
// Protocol checker for sync_serial_xcvr, attached by bind.
// Observes pins and the signals passed between register file and engine.
module ssx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic              ser_clk,
    input logic              ser_dout,
    input logic              tx_en,
    input logic              rx_en,
    input logic              load,
    input logic              frame_done,
    input logic              tx_empty,
    input logic              rx_full,
    input logic              ovr,
    input logic [DATA_W-1:0] rx_buf
);

    logic tx_write;
    assign tx_write = bus_sel && bus_wr && (bus_addr == 2'd2);

    // R3
    dout_hold_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk) |-> $stable(ser_dout));

    // R2
    txe_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !tx_write) |=> tx_empty);

    // R4
    rxf_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_full) |-> $past(frame_done));

    // R6
    ovr_keeps_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(rx_buf));

    // R7
    ovr_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr |-> !load);

    // R9
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !rx_en) |=> ser_clk);

    // R10
    dout_high_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ser_clk) && $past(!tx_en)) |-> ser_dout);

endmodule

bind sync_serial_xcvr ssx_chk #(.DATA_W(DATA_W)) u_ssx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .ser_clk    (ser_clk),
    .ser_dout   (ser_dout),
    .tx_en      (ctl_tx_en),
    .rx_en      (ctl_rx_en),
    .load       (eng_load),
    .frame_done (eng_done),
    .tx_empty   (st_tx_empty),
    .rx_full    (st_rx_full),
    .ovr        (st_ovr),
    .rx_buf     (rx_buf)
);

// File: tb/test_sync_serial_xcvr.sv
`timescale 1ns/1ps
// Bench: loopback slave model, directed corner cases and seeded random frames.
module test_sync_serial_xcvr;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       rx_irq, ser_clk, ser_dout;
    logic       ser_din = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    bit ended   = 1'b0;

    logic [7:0] slave_mem [64];
    logic [7:0] mosi_mem  [64];
    logic [7:0] slave_cur = 8'hFF;
    logic [7:0] mosi_sh = 8'h00;
    int slave_idx = 0, slave_bit = 0, mosi_cnt = 0, mosi_bit = 0;
    realtime t_fall = 0, t_rise = 0, low_ns = 0, high_ns = 0;

    always #2.5 clk = ~clk;

    sync_serial_xcvr i_sync_serial_xcvr (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .rx_irq    (rx_irq),
        .ser_clk   (ser_clk),
        .ser_dout  (ser_dout),
        .ser_din   (ser_din)
    );

    // Slave: present the next bit on each falling serial clock.
    always @(negedge ser_clk) if (rst_n) begin
        if (slave_bit == 0) begin
            slave_cur = slave_mem[slave_idx % 64];
            slave_idx++;
        end
        ser_din   = slave_cur[7 - slave_bit];
        slave_bit = (slave_bit + 1) % 8;
        t_fall    = $realtime;
        high_ns   = t_fall - t_rise;
    end

    // Slave: capture master data on each rising serial clock.
    always @(posedge ser_clk) if (rst_n) begin
        t_rise  = $realtime;
        low_ns  = t_rise - t_fall;
        mosi_sh = {mosi_sh[6:0], ser_dout};
        mosi_bit++;
        if (mosi_bit == 8) begin
            mosi_mem[mosi_cnt % 64] = mosi_sh;
            mosi_cnt++;
            mosi_bit = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic wait_flag(input int bitn, input logic val, input string tag);
        logic [7:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(2'd1, s);
            if (s[bitn] == val) return;
        end
        chk({tag, " timeout"}, 0, 1);
    endtask

    function automatic int half_of(input int sel);
        return 2 << sel;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        int f, h;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) slave_mem[i] = 8'($urandom);
        for (int i = 0; i < 64; i++) mosi_mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, s); chk("R1 status", s, 8'h01);
        rd(2'd0, s); chk("R1 control", s, 8'h00);
        chk("R1 irq", rx_irq, 0);
        chk("R1 sck", ser_clk, 1);
        chk("R1 dout", ser_dout, 1);

        // R9 no frame with both enables off
        wr(2'd2, 8'hA5);
        repeat (40) @(negedge clk);
        rd(2'd1, s); chk("R9 pending txe", s[0], 0);
        chk("R9 sck idle", ser_clk, 1);

        // R2 R3 R4 R5 first frame, divide 4
        f = mosi_cnt;
        wr(2'd0, 8'h07);
        wait_flag(1, 1'b1, "R4 rxf");
        chk("R5 irq set", rx_irq, 1);
        rd(2'd3, s); chk("R4 rx data", s, slave_mem[f % 64]);
        chk("R5 irq clear", rx_irq, 0);
        rd(2'd1, s); chk("R4 rxf cleared", s[1], 0);
        wait_flag(2, 1'b1, "R8 tend");
        chk("R3 mosi", mosi_mem[f % 64], 8'hA5);
        chk("R3 low half", int'(low_ns), 10);
        rd(2'd1, s); chk("R2 status quiet", s, 8'h05);
        wr(2'd1, 8'hFF);
        rd(2'd1, s); chk("R8 write one keeps", s, 8'h05);
        wr(2'd1, 8'hFB);
        rd(2'd1, s); chk("R8 write zero clears", s, 8'h01);

        // R8 quiet timing and R3 halves, divide 32
        h = half_of(3);
        f = mosi_cnt;
        wr(2'd0, 8'h37);
        wr(2'd2, 8'h3C);
        repeat (8) @(posedge ser_clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 2'd1;
        repeat (3 * h - 1) @(posedge clk);
        #1 chk("R8 quiet early", bus_rdata[2], 0);
        @(posedge clk);
        #1 chk("R8 quiet on time", bus_rdata[2], 1);
        @(negedge clk); bus_sel = 1'b0;
        chk("R3 low half div32", int'(low_ns), h * 5);
        chk("R3 high half div32", int'(high_ns), h * 5);
        chk("R3 mosi div32", mosi_mem[f % 64], 8'h3C);
        rd(2'd3, s); chk("R4 rx div32", s, slave_mem[f % 64]);

        // R6 R7 overrun, divide 4
        f = mosi_cnt;
        wr(2'd0, 8'h07);
        wr(2'd2, 8'h11);
        wait_flag(0, 1'b1, "R2 txe");
        wr(2'd2, 8'h22);
        wait_flag(3, 1'b1, "R6 ovr");
        rd(2'd1, s); chk("R6 ovr and rxf", s & 8'h0A, 8'h0A);
        chk("R5 irq with ovr", rx_irq, 1);
        rd(2'd3, s); chk("R6 old rx kept", s, slave_mem[f % 64]);
        wr(2'd2, 8'h33);
        repeat (100) @(negedge clk);
        rd(2'd1, s); chk("R7 no start txe", s[0], 0);
        chk("R7 no start frames", mosi_cnt, f + 2);
        chk("R7 sck idle", ser_clk, 1);
        wr(2'd1, 8'hFF);
        rd(2'd1, s); chk("R7 write one keeps ovr", s[3], 1);
        wr(2'd1, 8'hF7);
        wait_flag(1, 1'b1, "R7 resume");
        rd(2'd3, s); chk("R7 resumed rx", s, slave_mem[(f + 2) % 64]);
        chk("R7 resumed mosi", mosi_mem[(f + 2) % 64], 8'h33);
        wait_flag(2, 1'b1, "R8 tend");

        // R10 receive only
        f = mosi_cnt;
        wr(2'd0, 8'h02);
        wr(2'd2, 8'h00);
        wait_flag(1, 1'b1, "R10 rxf");
        rd(2'd3, s); chk("R10 rx data", s, slave_mem[f % 64]);
        chk("R10 dout high", mosi_mem[f % 64], 8'hFF);
        wait_flag(2, 1'b1, "R8 tend");

        // R11 transmit only
        f = mosi_cnt;
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h5A);
        wait_flag(2, 1'b1, "R11 tend");
        rd(2'd1, s); chk("R11 rx untouched", s, 8'h05);
        chk("R11 mosi", mosi_mem[f % 64], 8'h5A);

        // R2 R3 R4 seeded random bursts over all ratios
        for (int it = 0; it < 16; it++) begin
            int sel, n;
            logic [7:0] tb [3];
            sel = int'($urandom % 4);
            n   = 1 + int'($urandom % 3);
            for (int k = 0; k < 3; k++) tb[k] = 8'($urandom);
            f = mosi_cnt;
            wr(2'd0, 8'((sel << 4) | 3));
            wr(2'd2, tb[0]);
            for (int k = 1; k < n; k++) begin
                wait_flag(0, 1'b1, "R2 txe");
                wr(2'd2, tb[k]);
                wait_flag(1, 1'b1, "R4 rxf");
                rd(2'd3, s); chk("R4 random rx", s, slave_mem[(f + k - 1) % 64]);
            end
            wait_flag(1, 1'b1, "R4 rxf");
            rd(2'd3, s); chk("R4 random rx last", s, slave_mem[(f + n - 1) % 64]);
            wait_flag(2, 1'b1, "R8 tend");
            for (int k = 0; k < n; k++)
                chk("R3 random mosi", mosi_mem[(f + k) % 64], tb[k]);
            chk("R2 random frame count", mosi_cnt, f + n);
            rd(2'd1, s); chk("R6 random no ovr", s[3], 0);
            chk("R3 random low half", int'(low_ns), half_of(sel) * 5);
        end

        // R9 shutdown mid-frame
        wr(2'd0, 8'h33);
        wr(2'd2, 8'h81);
        repeat (3) @(posedge ser_clk);
        wr(2'd0, 8'h00);
        @(negedge clk);
        chk("R9 abort sck", ser_clk, 1);
        chk("R9 abort dout", ser_dout, 1);
        begin
            int lows = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (ser_clk == 1'b0) lows++;
            end
            chk("R9 clock stopped", lows, 0);
        end
        rd(2'd1, s); chk("R9 abort rxf", s[1], 0);

        if (!ended) begin
            ended = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule